// File: doc/BRIEF.md
# Receive Destination Address Filter

This block makes the keep-or-drop decision for an incoming Ethernet frame from its 48-bit destination address alone. The frame parser hands it the address together with a one-cycle strobe, and one clock later the block returns an accept flag and a code that says why the frame was kept. Framing, CRC and counting happen in other blocks.

The filter checks four things, in a fixed priority order. The first is a promiscuous switch. The second is a bank of eight exact-match station addresses: one primary and seven extra. The third is the all-ones broadcast address, which is always kept. The last is a 64-bin multicast hash table. Software programs the filter through a simple word-addressed write port. The hash table has no direct window. Software sets or clears one bin per write through a control word that carries the bin index and the bin's new value.

The destination address is packed with the first byte on the wire in bits 47:40. This puts the individual/group bit at bit 40.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, dec_valid, dec_accept and dec_reason are 0, promiscuous mode is off, every hash bin is clear and every station register is zero. As a result, the all-zero address is an exact match until the stations are reprogrammed.
- R2: dec_valid is high exactly one cycle after dst_valid is high. While dec_valid is low, dec_accept and dec_reason are 0.
- R3: The write map (word index on wr_addr) has these words:
  - Word 0, bit 0: promiscuous enable.
  - Word 1: hash control.
  - Word 2+2k: the low register of station k, for k = 0..7.
  - Word 3+2k: the high register of station k, with bits 15:0 used.
  - Writes to any other word index change nothing.
- R4: Station k holds address bytes b0..b5, where b0 is the first byte on the wire. The low register holds b0 in bits 7:0, b1 in 15:8, b2 in 23:16 and b3 in 31:24. The high register holds b4 in bits 7:0 and b5 in 15:8. A destination equal to the stored address is an exact match, for every one of the eight stations.
- R5: The 6-bit hash of the address is built group by group. For i = 0..5, hash bit (5−i) is the XOR of the packed address bits [8i+7:8i].
- R6: A write to hash control selects the bin given by bits 5:0. It sets that bin when bit 8 is 1 and clears it when bit 8 is 0. No other bin changes.
- R7: A hash hit counts only when address bit 40 (the group bit) is 1. A unicast address whose bin is set is not accepted by the hash.
- R8: With promiscuous mode on, every address is accepted with reason 1.
- R9: The all-ones address is always accepted.
- R10: The reason codes follow this priority: 1 promiscuous, then 2 exact match, then 3 broadcast, then 4 hash hit. Code 0 means rejected, and dec_accept is high exactly when the code is nonzero.
- R11: A write applies to addresses presented from the next cycle on. An address strobed in the same cycle as a write is judged with the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (5) | Register word index |
| wr_data | input | 32 | Register write data |
| dst_valid | input | 1 | Destination address present |
| dst_addr | input | 48 | Destination address, first wire byte in 47:40 |
| dec_valid | output | 1 | Decision valid, one cycle after dst_valid |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | Reason code: 0 reject, 1 promiscuous, 2 exact, 3 broadcast, 4 hash |

## Verification
The assertions assume that dst_addr is stable and meaningful only in cycles where dst_valid is high. They also assume that the hash-control write data carries a bin index below 64 in its low bits. The bench drives the address only together with the strobe. It takes every bin index from a 6-bit field, so the assumption holds. A write and a lookup in the same cycle are legal and are exercised on purpose. The same-edge check expects the old settings, because the assertions only relate the registered state seen at the strobe to the decision that follows it.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
    localparam int MAC_W   = 48;
    localparam int GROUP_W = 8;
    localparam int GRP_BIT = 40;

    typedef enum logic [2:0] {
        RSN_NONE    = 3'd0,
        RSN_PROMISC = 3'd1,
        RSN_EXACT   = 3'd2,
        RSN_BCAST   = 3'd3,
        RSN_HASH    = 3'd4
    } reason_e;

    typedef struct packed {
        logic    promisc;
        logic    valid;
        logic    accept;
        reason_e reason;
    } filt_state_t;
endpackage

// File: rtl/rxaf_station_bank.sv
module rxaf_station_bank #(
    parameter int NUM_ST = 8,
    parameter int AW     = 5,
    parameter int BASE   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [31:0]               wr_data,
    input  logic [rxaf_pkg::MAC_W-1:0] dst_addr,
    output logic [NUM_ST-1:0]         match_o
);
    logic [31:0] lo_q [NUM_ST];
    logic [31:0] lo_d [NUM_ST];
    logic [15:0] hi_q [NUM_ST];
    logic [15:0] hi_d [NUM_ST];

    always_comb begin
        for (int k = 0; k < NUM_ST; k++) begin
            lo_d[k] = lo_q[k];
            hi_d[k] = hi_q[k];
            if (wr_en && wr_addr == AW'(BASE + 2*k))
                lo_d[k] = wr_data;
            if (wr_en && wr_addr == AW'(BASE + 2*k + 1))
                hi_d[k] = wr_data[15:0];
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_ST; k++) begin
            if (!rst_n) begin
                lo_q[k] <= '0;
                hi_q[k] <= '0;
            end else begin
                lo_q[k] <= lo_d[k];
                hi_q[k] <= hi_d[k];
            end
        end
    end

    for (genvar g = 0; g < NUM_ST; g++) begin : g_cmp
        logic [rxaf_pkg::MAC_W-1:0] wire_order;
        // stored byte 0 is the first wire byte, which sits at the top of dst_addr
        assign wire_order = {lo_q[g][7:0], lo_q[g][15:8], lo_q[g][23:16],
                             lo_q[g][31:24], hi_q[g][7:0], hi_q[g][15:8]};
        assign match_o[g] = (wire_order == dst_addr);
    end
endmodule

// File: rtl/rxaf_hash_bins.sv
module rxaf_hash_bins #(
    parameter int HASH_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctl_wr,
    input  logic [HASH_W-1:0]         ctl_idx,
    input  logic                      ctl_val,
    input  logic [rxaf_pkg::MAC_W-1:0] dst_addr,
    output logic                      bin_hit_o
);
    localparam int NBINS = 1 << HASH_W;

    logic [NBINS-1:0]  bins_d, bins_q;
    logic [HASH_W-1:0] hash;

    always_comb begin
        for (int i = 0; i < HASH_W; i++)
            hash[HASH_W-1-i] = ^dst_addr[i*rxaf_pkg::GROUP_W +: rxaf_pkg::GROUP_W];
    end

    always_comb begin
        bins_d = bins_q;
        if (ctl_wr)
            bins_d[ctl_idx] = ctl_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bins_q <= '0;
        else        bins_q <= bins_d;
    end

    assign bin_hit_o = bins_q[hash];

    // R6
    bin_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_val |=> bins_q[$past(ctl_idx)]);
    // R6
    bin_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !ctl_val |=> !bins_q[$past(ctl_idx)]);
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
    parameter int NUM_STATIONS = 8,
    parameter int HASH_W       = 6,
    parameter int ADDR_W       = $clog2(2 + 2*NUM_STATIONS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [31:0]                wr_data,
    input  logic                       dst_valid,
    input  logic [rxaf_pkg::MAC_W-1:0] dst_addr,
    output logic                       dec_valid,
    output logic                       dec_accept,
    output logic [2:0]                 dec_reason
);
    import rxaf_pkg::*;

    localparam logic [ADDR_W-1:0] CTRL_WORD = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] HASH_WORD = ADDR_W'(1);
    localparam int                ST_BASE   = 2;
    localparam int                VAL_BIT   = 8;

    filt_state_t           st_d, st_q;
    logic [NUM_STATIONS-1:0] st_match;
    logic                  bin_hit;
    logic                  hash_wr;

    assign hash_wr = wr_en && (wr_addr == HASH_WORD);

    rxaf_station_bank #(
        .NUM_ST (NUM_STATIONS),
        .AW     (ADDR_W),
        .BASE   (ST_BASE)
    ) u_stations (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .dst_addr (dst_addr),
        .match_o  (st_match)
    );

    rxaf_hash_bins #(
        .HASH_W (HASH_W)
    ) u_hash (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (hash_wr),
        .ctl_idx   (wr_data[HASH_W-1:0]),
        .ctl_val   (wr_data[VAL_BIT]),
        .dst_addr  (dst_addr),
        .bin_hit_o (bin_hit)
    );

    always_comb begin
        reason_e why;
        st_d = st_q;
        if (wr_en && wr_addr == CTRL_WORD)
            st_d.promisc = wr_data[0];

        if (st_q.promisc)                      why = RSN_PROMISC;
        else if (|st_match)                    why = RSN_EXACT;
        else if (&dst_addr)                    why = RSN_BCAST;
        else if (dst_addr[GRP_BIT] && bin_hit) why = RSN_HASH;
        else                                   why = RSN_NONE;

        st_d.valid  = dst_valid;
        st_d.accept = dst_valid && (why != RSN_NONE);
        st_d.reason = dst_valid ? why : RSN_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{promisc: 1'b0, valid: 1'b0, accept: 1'b0, reason: RSN_NONE};
        else        st_q <= st_d;
    end

    assign dec_valid  = st_q.valid;
    assign dec_accept = st_q.accept;
    assign dec_reason = st_q.reason;

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |=> dec_valid);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_accept && dec_reason == 3'd0));
    // R8
    promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid && st_q.promisc |=> dec_accept && dec_reason == 3'd1);
    // R9
    bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid && (&dst_addr) |=> dec_accept);
    // R7
    group_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_reason == 3'd4 |-> $past(dst_addr[GRP_BIT]));
endmodule

// File: tb/rx_dest_filter_tb.sv
`timescale 1ns/1ps
module rx_dest_filter_tb_top;
    localparam int NST = 8;
    localparam int AW  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        dst_valid = 1'b0;
    logic [47:0] dst_addr = '0;
    logic        dec_valid, dec_accept;
    logic [2:0]  dec_reason;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_lo [NST];
    logic [15:0] m_hi [NST];
    logic [63:0] m_bins;
    logic        m_prom;

    logic [2:0]  exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    rx_dest_filter dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dst_valid(dst_valid), .dst_addr(dst_addr),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
    );

    function automatic logic [5:0] hash6(logic [47:0] a);
        logic [5:0] h;
        for (int i = 0; i < 6; i++) h[5-i] = ^a[8*i +: 8];
        return h;
    endfunction

    function automatic logic [47:0] st_mac(int k);
        return {m_lo[k][7:0], m_lo[k][15:8], m_lo[k][23:16], m_lo[k][31:24],
                m_hi[k][7:0], m_hi[k][15:8]};
    endfunction

    function automatic logic [2:0] model(logic [47:0] a);
        logic ex = 1'b0;
        for (int k = 0; k < NST; k++) if (st_mac(k) == a) ex = 1'b1;
        if (m_prom) return 3'd1;
        if (ex) return 3'd2;
        if (&a) return 3'd3;
        if (a[40] && m_bins[hash6(a)]) return 3'd4;
        return 3'd0;
    endfunction

    task automatic model_wr(logic [AW-1:0] ad, logic [31:0] d);
        if (ad == 0) m_prom = d[0];
        else if (ad == 1) m_bins[d[5:0]] = d[8];
        else if (ad < AW'(2 + 2*NST)) begin
            if (ad[0] == 1'b0) m_lo[(ad-2)/2] = d;
            else               m_hi[(ad-2)/2] = d[15:0];
        end
    endtask

    task automatic reg_wr(logic [AW-1:0] ad, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ad; wr_data = d;
        model_wr(ad, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_station(int k, logic [47:0] mac);
        reg_wr(AW'(2 + 2*k), {mac[23:16], mac[31:24], mac[39:32], mac[47:40]});
        reg_wr(AW'(3 + 2*k), {16'h0, mac[7:0], mac[15:8]});
    endtask

    task automatic look(logic [47:0] a, string tag);
        @(negedge clk);
        dst_valid = 1'b1; dst_addr = a;
        exp_q.push_back(model(a));
        tag_q.push_back(tag);
        @(negedge clk);
        dst_valid = 1'b0;
    endtask

    task automatic look_and_wr(logic [47:0] a, logic [AW-1:0] ad, logic [31:0] d, string tag);
        @(negedge clk);
        dst_valid = 1'b1; dst_addr = a;
        wr_en = 1'b1; wr_addr = ad; wr_data = d;
        exp_q.push_back(model(a));
        tag_q.push_back(tag);
        model_wr(ad, d);
        @(negedge clk);
        dst_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic check_val(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a decision appears
    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            if (exp_q.size() == 0) begin
                check_val("R2 unexpected decision", 1, 0);
            end else begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_val(t, dec_reason, e);
                check_val({t, " accept"}, dec_accept, (e != 0) ? 1 : 0);
            end
        end
    end

    initial begin
        #(20ns * 150000);
        check_val("watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] u, g;
        for (int k = 0; k < NST; k++) begin m_lo[k] = '0; m_hi[k] = '0; end
        m_bins = '0; m_prom = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs
        check_val("R1 valid", dec_valid, 0);
        check_val("R1 accept", dec_accept, 0);
        check_val("R1 reason", dec_reason, 0);
        look(48'h0, "R1 zero addr exact after reset");
        look(48'h021122334455, "R1 unicast reject after reset");
        look(48'h01005E000001, "R1 group no bins after reset");
        @(negedge clk);
        check_val("R2 idle valid", dec_valid, 0);

        // R4 byte order and all eight stations
        set_station(0, 48'h001122334455);
        look(48'h001122334455, "R4 station0 exact");
        look(48'h554433221100, "R4 byte reversed reject");
        for (int k = 1; k < NST; k++) set_station(k, 48'h02A0B0C0D000 + 48'(k * 7));
        for (int k = 0; k < NST; k++) look(st_mac(k), "R4 exact per station");
        look(48'h0, "R4 zero no longer matches");

        // R9 broadcast and R10 priority
        look(48'hFFFFFFFFFFFF, "R9 broadcast");
        set_station(3, 48'hFFFFFFFFFFFF);
        look(48'hFFFFFFFFFFFF, "R10 exact above broadcast");
        set_station(3, 48'h02A0B0C0D015);

        // R5 R6 R7 hash behaviour
        u = 48'h02AABBCCDDEE;
        g = u | (48'h1 << 40);
        reg_wr(1, 32'h100 | 32'(hash6(u)));
        look(u, "R7 unicast ignores set bin");
        look(g, "R5 group bin clear reject");
        reg_wr(1, 32'h100 | 32'(hash6(g)));
        look(g, "R5 R6 group hash hit");
        reg_wr(1, 32'(hash6(g)));
        look(g, "R6 bin cleared");
        look(u, "R7 unicast still reject");

        // R3 unmapped words ignored
        reg_wr(AW'(20), 32'hFFFFFFFF);
        reg_wr(AW'(31), 32'h00000001);
        look(48'h021122334499, "R3 unmapped write no effect");
        look(st_mac(5), "R3 station intact");

        // R8 promiscuous
        reg_wr(0, 32'h1);
        look(48'h021122334499, "R8 promisc unicast");
        look(st_mac(2), "R10 promisc above exact");
        reg_wr(0, 32'h0);
        look(48'h021122334499, "R8 promisc off reject");

        // R11 same-cycle write uses old settings
        look_and_wr(48'h021122334499, 0, 32'h1, "R11 old state on write edge");
        look(48'h021122334499, "R11 new state next cycle");
        look_and_wr(48'h021122334499, 0, 32'h0, "R11 old promisc on clear edge");

        // mixed pattern sweep
        for (int i = 0; i < 16; i++) reg_wr(1, 32'h100 | ($urandom & 32'h3F));
        for (int i = 0; i < 300; i++) begin
            logic [47:0] a;
            a = {$urandom, $urandom} & 48'hFFFFFFFFFFFF;
            case (i % 5)
                0: a = st_mac(i % NST);
                1: a[40] = 1'b1;
                2: a[40] = 1'b0;
                3: a = (i % 15 == 3) ? 48'hFFFFFFFFFFFF : a;
                default: ;
            endcase
            look(a, "R10 mixed sweep");
        end

        repeat (4) @(negedge clk);
        check_val("R2 scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule